// File: doc/BRIEF.md
# Three-Wire Write-Only Serializer

This block turns bytes written by a host into a three-wire slave stream made of a serial clock, a serial data line and an enable line. The host has two ways to write a byte. A continue write opens a transfer or extends it, and is used for the slave address and for intermediate bytes. A final write sends its byte and then closes the transfer. A single-byte transfer is one final write. A longer transfer is an address byte, then zero or more intermediate bytes, then one final byte.

A two-bit mode input chooses how the enable line behaves. It can stay high for all the data of a transfer, pulse for one serial clock period at the start, or pulse for one serial clock period at the end. Mode 00 switches the block off. The serial clock runs at a rate set by a divider input. Each byte fills a slot of eleven serial clock periods: eight bit periods and three idle periods. A busy output covers the whole slot so the host can pace its writes. The block only writes and never samples anything from the slave.

Top module: `tw_serializer`

## Requirements
- R1: After reset, ser_clk, ser_data, ser_en, busy and overrun are all low.
- R2: Each byte goes out MSB first with exactly eight rising edges of ser_clk. ser_data changes only while ser_clk is low.
- R3: One serial clock period is 2*(clk_div+1) system clocks. busy stays high for 11 such periods (22*(clk_div+1) system clocks) from the cycle after the write. ser_clk and ser_data stay low during the last three periods and whenever busy is low.
- R4: In mode 01, ser_en rises with the first byte of a transfer. It stays high through continue bytes and through the gaps between them. It falls at the end of the eighth bit of the final byte, so it is high for 16*(clk_div+1) system clocks of the final byte's slot.
- R5: In mode 10, ser_en is high for exactly the first serial period (2*(clk_div+1) system clocks) of the first byte of a transfer. It is low at all other times.
- R6: In mode 11, ser_en is high for exactly the serial period of the last bit of the final byte. It is low at all other times.
- R7: A write with wr_last=0 leaves the transfer open. A write with wr_last=1 closes it, and the next write then starts a new transfer.
- R8: A write made while busy is high is ignored: the byte in flight and the slot length do not change. overrun goes high for one system clock in the cycle that follows.
- R9: With cfg_mode=00, all three serial outputs and busy are low from the next clock on. Writes are ignored without flagging overrun, and any transfer in progress is aborted and closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Enable style: 00 off, 01 level, 10 start pulse, 11 end pulse |
| clk_div | input | DIV_W | Serial half-period in system clocks, minus one |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| wr_last | input | 1 | 1 selects the final-byte register, 0 the continue register |
| wr_data | input | 8 | Byte to send |
| ser_clk | output | 1 | Serial clock to the slave |
| ser_data | output | 1 | Serial data to the slave |
| ser_en | output | 1 | Enable to the slave |
| busy | output | 1 | High while a byte slot is in progress |
| overrun | output | 1 | One-cycle pulse after a write rejected for being busy |

## Verification
The bench builds the block with DIV_W=4 and drives clk_div from 0 to 3. With these values it checks the one-to-one and the stretched serial clock against slot lengths of 22 to 88 system clocks, and the whole walk stays short. The vector table puts all three enable styles through single-byte and multi-byte transfers. The directed tests cover an intrusive write in the middle of a slot, writes made while the block is off, and an abort in the middle of a byte followed by a fresh transfer.

// File: rtl/tw_serializer.sv
module tw_serializer #(
  parameter int DIV_W  = 8,
  parameter int BYTE_W = 8,
  parameter int GAP    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             wr_en,
  input  logic             wr_last,
  input  logic [7:0]       wr_data,
  output logic             ser_clk,
  output logic             ser_data,
  output logic             ser_en,
  output logic             busy,
  output logic             overrun
);
  localparam int SLOT  = BYTE_W + GAP;
  localparam int CNT_W = $clog2(SLOT + 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOT - 1);

  logic              busy_q, phase_q, open_q, first_q, last_q, ovr_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;

  wire on      = cfg_mode != 2'b00;
  wire accept  = on && wr_en && !busy_q;
  wire tick    = busy_q && (div_q == clk_div);
  wire in_data = busy_q && (cnt_q < CNT_W'(BYTE_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      open_q  <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      ovr_q   <= 1'b0;
      div_q   <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else if (!on) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      open_q  <= 1'b0;
      ovr_q   <= 1'b0;
      div_q   <= '0;
      cnt_q   <= '0;
    end else begin
      ovr_q <= wr_en && busy_q;
      if (accept) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
        div_q   <= '0;
        cnt_q   <= '0;
        sh_q    <= BYTE_W'(wr_data);
        last_q  <= wr_last;
        first_q <= !open_q;
        open_q  <= 1'b1;
      end else if (busy_q) begin
        if (tick) begin
          div_q <= '0;
          if (!phase_q) begin
            phase_q <= 1'b1;
          end else begin
            phase_q <= 1'b0;
            if (cnt_q == LAST_SLOT) busy_q <= 1'b0;
            else                    cnt_q  <= cnt_q + 1'b1;
            if (in_data) sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
            if (last_q && cnt_q == LAST_BIT) open_q <= 1'b0;
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (cfg_mode)
      2'b01:   ser_en = open_q;
      2'b10:   ser_en = busy_q && first_q && cnt_q == '0;
      2'b11:   ser_en = busy_q && last_q && cnt_q == LAST_BIT;
      default: ser_en = 1'b0;
    endcase
  end

  assign ser_clk  = in_data && phase_q;
  assign ser_data = in_data && sh_q[BYTE_W-1];
  assign busy     = busy_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/tw_serializer_chk.sv
module tw_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mode,
  input logic       wr_en,
  input logic       ser_clk,
  input logic       ser_data,
  input logic       ser_en,
  input logic       busy,
  input logic       overrun
);
  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode == 2'b00 |=> !busy && !ser_clk && !ser_data && !ser_en);

  assert_data_held_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));

  assert_idle_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_clk && !ser_data);

  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(busy && wr_en && cfg_mode != 2'b00));

  assert_start_pulse_in_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b10 && ser_en) |-> busy);

  assert_end_pulse_in_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b11 && ser_en) |-> busy);

  assert_write_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && cfg_mode != 2'b00) |=> busy);
endmodule

bind tw_serializer tw_serializer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .wr_en(wr_en),
  .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
  .busy(busy), .overrun(overrun)
);

// File: tb/test_tw_serializer.sv
`timescale 1ns/1ps
module test_tw_serializer;
  localparam int DIV_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b01;
  logic [DIV_W-1:0] clk_div = '0;
  logic wr_en = 1'b0, wr_last = 1'b0;
  logic [7:0] wr_data = '0;
  logic ser_clk, ser_data, ser_en, busy, overrun;

  int checks = 0, fails = 0;
  bit opened = 1'b0;

  always #4 clk = ~clk;

  tw_serializer #(.DIV_W(DIV_W)) i_tw_serializer (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .clk_div(clk_div),
    .wr_en(wr_en), .wr_last(wr_last), .wr_data(wr_data),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
    .busy(busy), .overrun(overrun)
  );

  // [15:12] div, [11:10] mode, [9] final, [7:0] data
  localparam logic [15:0] VEC [10] = '{
    16'h06A5, 16'h143C, 16'h1481, 16'h167E, 16'h08C3,
    16'h0A01, 16'h2CFF, 16'h2E00, 16'h3A96, 16'h0E5A
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int d, input logic [1:0] m, input bit f,
                      input logic [7:0] data, input int intr);
    int n = 0, e = 0, r = 0;
    logic [7:0] rx = '0;
    logic prev = 1'b0;
    bit first;
    int unit;
    @(negedge clk);
    cfg_mode = m; clk_div = DIV_W'(d);
    wr_en = 1'b1; wr_last = f; wr_data = data;
    first = !opened;
    unit = d + 1;
    @(negedge clk);
    wr_en = 1'b0;
    while (busy && n < 400) begin
      if (intr >= 0 && n == intr + 1) chk("R8 overrun pulse", overrun, 1);
      if (ser_en) e++;
      if (ser_clk && !prev) begin rx = {rx[6:0], ser_data}; r++; end
      prev = ser_clk;
      n++;
      if (intr >= 0 && n - 1 == intr) begin wr_en = 1'b1; wr_last = !f; wr_data = ~data; end
      else wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;
    opened = !f;
    chk("R2 byte received MSB first", rx, data);
    chk("R2 rising edges", r, 8);
    chk("R3 busy length", n, 22 * unit);
    case (m)
      2'b01: chk("R4 level enable cycles", e, f ? 16 * unit : 22 * unit);
      2'b10: chk("R5 start pulse cycles", e, first ? 2 * unit : 0);
      default: chk("R6 end pulse cycles", e, f ? 2 * unit : 0);
    endcase
    chk("R7 enable after slot", ser_en, (m == 2'b01 && !f) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ser_clk reset", ser_clk, 0);
    chk("R1 ser_data reset", ser_data, 0);
    chk("R1 ser_en reset", ser_en, 0);
    chk("R1 busy reset", busy, 0);
    chk("R1 overrun reset", overrun, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VEC[i])
      send(int'(VEC[i][15:12]), VEC[i][11:10], VEC[i][9], VEC[i][7:0], -1);

    // R8: intrusive write in mid-slot
    send(1, 2'b01, 1'b1, 8'hC6, 9);

    // R9: writes while off are ignored
    @(negedge clk);
    cfg_mode = 2'b00; wr_en = 1'b1; wr_last = 1'b0; wr_data = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 busy stays low when off", busy, 0);
    chk("R9 no overrun when off", overrun, 0);
    chk("R9 enable low when off", ser_en, 0);

    // R9: abort mid-byte and reopen
    @(negedge clk);
    cfg_mode = 2'b01; clk_div = '0; wr_en = 1'b1; wr_last = 1'b0; wr_data = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 busy before abort", busy, 1);
    cfg_mode = 2'b00;
    @(negedge clk);
    chk("R9 abort clears busy", busy, 0);
    chk("R9 abort clears ser_data", ser_data, 0);
    cfg_mode = 2'b01;
    @(negedge clk);
    chk("R9 abort closes transfer", ser_en, 0);
    opened = 1'b0;
    send(0, 2'b10, 1'b1, 8'h3B, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule